// File: doc/BRIEF.md
# Interleave Target Decoder

This block sits in a host bridge and turns a host physical address into the number of the downstream root port that owns it. Software first programs three 32-bit registers through a simple write port: a control word and two target-list words. The control word holds a committed flag, a granularity code and a ways code. Each target-list word holds four one-byte port numbers, so the two words together hold eight entries.

A lookup is a one-cycle pulse on the request input with an address. One clock later the response strobe rises with a hit flag and a port number. The address is first divided by the interleave granularity, which is 256 bytes shifted left by the granularity code. The quotient, taken modulo 2 to the power of the ways code, gives the slot in the target list. The port number is the byte stored in that slot. A decoder that is not committed, or that holds a ways code it cannot serve, reports a miss.

Top module: `ilv_target_lookup`

## Requirements
- R1: After reset all three registers read as zero, so the decoder is uncommitted. The response strobe, the hit flag and the port output are all zero.
- R2: The response strobe is high exactly in the cycle after a cycle in which the request input was high, and it is low at all other times. When the response strobe is low, the hit flag and the port output are zero.
- R3: When the committed flag (control bit 0) is clear, a lookup returns hit 0 and port 0.
- R4: A ways code (control bits 11:8) above 3 makes a lookup return hit 0 and port 0, even when the decoder is committed.
- R5: When the decoder is committed and the ways code is 3 or less, the slot is (address >> (8 + G)) mod 2^W. Here G is the granularity code in control bits 7:4 and W is the ways code.
- R6: Slots 0 to 3 return byte (slot×8) of the low target word. Slots 4 to 7 return byte ((slot−4)×8) of the high target word. A valid slot always gives hit 1.
- R7: A write goes to the control word at byte offset 0x0, to the low target word at 0x4 and to the high target word at 0x8. A write to any other offset changes no lookup result.
- R8: A lookup uses the register contents from before any write made in the same cycle. The write affects the next lookup.
- R9: Address bits below the granularity boundary have no effect on the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte offset of the register to write |
| reg_wdata_i | input | 32 | Write data |
| lkp_req_i | input | 1 | Lookup request |
| lkp_addr_i | input | 52 | Host physical address to decode |
| rsp_vld_o | output | 1 | Response strobe, one cycle after a request |
| rsp_hit_o | output | 1 | A valid target was found |
| rsp_port_o | output | 8 | Selected root-port number, zero on a miss |

## Verification
The bench sweeps every combination of the committed flag, ways codes 0 to 5 and granularity codes 0 to 6. For each combination it loads a fresh target list in which every byte is different. It then issues sixteen addresses, one per granularity stride, each with junk in the low bits and in the high bits. The modulo wrap therefore reaches every slot, and each slot shows a different byte. A wrong byte lane, a wrong shift amount or a wrong half of the list then gives a visibly wrong port. A miss with a nonzero port is caught as well. The uncommitted pass and the ways codes 4 and 5 separate the two miss conditions from a correct decode. A write to an unmapped offset, and a write in the same cycle as a request, show whether the register decode and the lookup timing are right.

// File: rtl/ilv_lookup_pkg.sv
package ilv_lookup_pkg;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned TLO_OFS  = 4;
  localparam int unsigned THI_OFS  = 8;

  localparam int unsigned CMT_BIT = 0;
  localparam int unsigned IG_LSB  = 4;
  localparam int unsigned IW_LSB  = 8;
  localparam int unsigned FLD_W   = 4;

  typedef struct packed {
    logic [FLD_W-1:0] iw;
    logic [FLD_W-1:0] ig;
    logic             commit;
  } ilv_ctrl_t;
endpackage

// File: rtl/ilv_regfile.sv
module ilv_regfile
  import ilv_lookup_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned OFS_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [OFS_W-1:0]   ofs_i,
  input  logic [REG_W-1:0]   wdata_i,
  output ilv_ctrl_t          ctrl_o,
  output logic [2*REG_W-1:0] tlist_o
);
  logic             cmt_q;
  logic [FLD_W-1:0] ig_q, iw_q;
  logic [REG_W-1:0] tlo_q, thi_q;

  logic sel_ctrl, sel_tlo, sel_thi;
  assign sel_ctrl = we_i && (ofs_i == OFS_W'(CTRL_OFS));
  assign sel_tlo  = we_i && (ofs_i == OFS_W'(TLO_OFS));
  assign sel_thi  = we_i && (ofs_i == OFS_W'(THI_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmt_q <= 1'b0;
      ig_q  <= '0;
      iw_q  <= '0;
    end else if (sel_ctrl) begin
      cmt_q <= wdata_i[CMT_BIT];
      ig_q  <= wdata_i[IG_LSB +: FLD_W];
      iw_q  <= wdata_i[IW_LSB +: FLD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tlo_q <= '0;
    else if (sel_tlo) tlo_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      thi_q <= '0;
    else if (sel_thi) thi_q <= wdata_i;
  end

  assign ctrl_o  = '{iw: iw_q, ig: ig_q, commit: cmt_q};
  // high word above low word: entry k sits at bits k*ENTRY_W
  assign tlist_o = {thi_q, tlo_q};
endmodule

// File: rtl/ilv_index_calc.sv
module ilv_index_calc
  import ilv_lookup_pkg::*;
#(
  parameter int unsigned ADDR_W    = 52,
  parameter int unsigned GRAN_BASE = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ilv_ctrl_t         ctrl_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ok_o
);
  localparam int unsigned MAX_IW = IDX_W;
  localparam int unsigned SH_W   = $clog2(GRAN_BASE + (1 << FLD_W)) + 1;

  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] quot;
  logic [IDX_W-1:0]  mask;

  assign shamt = SH_W'(GRAN_BASE) + SH_W'(ctrl_i.ig);
  assign quot  = addr_i >> shamt;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) mask[i] = (32'(i) < 32'(ctrl_i.iw));
  end

  assign idx_o = quot[IDX_W-1:0] & mask;
  assign ok_o  = ctrl_i.commit && (32'(ctrl_i.iw) <= MAX_IW);
endmodule

// File: rtl/ilv_target_sel.sv
module ilv_target_sel #(
  parameter int unsigned ENTRY_W     = 8,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned IDX_W       = 3
) (
  input  logic [NUM_ENTRIES*ENTRY_W-1:0] tlist_i,
  input  logic [IDX_W-1:0]               idx_i,
  output logic [ENTRY_W-1:0]             entry_o
);
  logic [ENTRY_W-1:0] ent [NUM_ENTRIES];

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_unpack
    assign ent[k] = tlist_i[k*ENTRY_W +: ENTRY_W];
  end

  assign entry_o = ent[idx_i];
endmodule

// File: rtl/ilv_target_lookup.sv
module ilv_target_lookup
  import ilv_lookup_pkg::*;
#(
  parameter int unsigned ADDR_W      = 52,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned OFS_W       = 4,
  parameter int unsigned ENTRY_W     = 8,
  parameter int unsigned GRAN_BASE   = 8,
  parameter int unsigned NUM_ENTRIES = 2 * REG_W / ENTRY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [OFS_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic               lkp_req_i,
  input  logic [ADDR_W-1:0]  lkp_addr_i,
  output logic               rsp_vld_o,
  output logic               rsp_hit_o,
  output logic [ENTRY_W-1:0] rsp_port_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  ilv_ctrl_t                      ctrl;
  logic [NUM_ENTRIES*ENTRY_W-1:0] tlist;
  logic [IDX_W-1:0]               lkp_idx;
  logic                           lkp_ok;
  logic [ENTRY_W-1:0]             lkp_entry;

  ilv_regfile #(.REG_W(REG_W), .OFS_W(OFS_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .ofs_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .tlist_o (tlist)
  );

  ilv_index_calc #(.ADDR_W(ADDR_W), .GRAN_BASE(GRAN_BASE), .IDX_W(IDX_W)) u_idx (
    .addr_i (lkp_addr_i),
    .ctrl_i (ctrl),
    .idx_o  (lkp_idx),
    .ok_o   (lkp_ok)
  );

  ilv_target_sel #(.ENTRY_W(ENTRY_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_sel (
    .tlist_i (tlist),
    .idx_i   (lkp_idx),
    .entry_o (lkp_entry)
  );

  logic             ctrl_commit;
  logic [FLD_W-1:0] ctrl_iw;
  assign ctrl_commit = ctrl.commit;
  assign ctrl_iw     = ctrl.iw;

  // lookup samples registers before a same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o  <= 1'b0;
      rsp_hit_o  <= 1'b0;
      rsp_port_o <= '0;
    end else begin
      rsp_vld_o  <= lkp_req_i;
      rsp_hit_o  <= lkp_req_i && lkp_ok;
      rsp_port_o <= (lkp_req_i && lkp_ok) ? lkp_entry : '0;
    end
  end
endmodule

// File: rtl/ilv_lookup_chk.sv
module ilv_lookup_chk #(
  parameter int unsigned ENTRY_W = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned FLD_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lkp_req_i,
  input logic               rsp_vld_o,
  input logic               rsp_hit_o,
  input logic [ENTRY_W-1:0] rsp_port_o,
  input logic               ctrl_commit,
  input logic [FLD_W-1:0]   ctrl_iw,
  input logic [IDX_W-1:0]   lkp_idx,
  input logic               lkp_ok
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> rsp_vld_o); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !rsp_vld_o); // R2
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_vld_o); // R2
  AST_NO_HIT_UNCOMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && !ctrl_commit) |=> !rsp_hit_o); // R3
  AST_MISS_PORT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_port_o == '0)); // R3
  AST_NO_HIT_BAD_WAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && (ctrl_iw > 4'd3)) |=> !rsp_hit_o); // R4
  AST_INDEX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_ok |-> ((32'(lkp_idx) >> ctrl_iw) == 0)); // R5
endmodule

bind ilv_target_lookup ilv_lookup_chk #(
  .ENTRY_W (ENTRY_W),
  .IDX_W   (IDX_W),
  .FLD_W   (ilv_lookup_pkg::FLD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_req_i   (lkp_req_i),
  .rsp_vld_o   (rsp_vld_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_port_o  (rsp_port_o),
  .ctrl_commit (ctrl_commit),
  .ctrl_iw     (ctrl_iw),
  .lkp_idx     (lkp_idx),
  .lkp_ok      (lkp_ok)
);

// File: tb/sim_ilv_target_lookup.sv
module sim_ilv_target_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic        req = 1'b0;
  logic [51:0] addr = '0;
  logic        vld, hit;
  logic [7:0]  port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl = '0, m_lo = '0, m_hi = '0;

  always #10 clk = ~clk;

  ilv_target_lookup u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .lkp_req_i(req), .lkp_addr_i(addr),
    .rsp_vld_o(vld), .rsp_hit_o(hit), .rsp_port_o(port)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // returns {hit, port}
  function automatic logic [8:0] model(input logic [31:0] c, input logic [31:0] lo,
                                       input logic [31:0] hi, input logic [51:0] a);
    int ig, iw;
    longint unsigned slot, gran;
    logic [7:0] p;
    ig = int'(c[7:4]);
    iw = int'(c[11:8]);
    if (!c[0] || iw > 3) return 9'd0;
    gran = 64'd256 << ig;
    slot = (64'(a) / gran) % (64'd1 << iw);
    if (slot < 4) p = 8'(lo >> (slot * 8));
    else          p = 8'(hi >> ((slot - 4) * 8));
    return {1'b1, p};
  endfunction

  task automatic wr(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = o; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (o == 4'h0) m_ctrl = d;
    else if (o == 4'h4) m_lo = d;
    else if (o == 4'h8) m_hi = d;
  endtask

  task automatic look(input logic [51:0] a, input string rq);
    logic [8:0] e;
    e = model(m_ctrl, m_lo, m_hi, a);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    check(vld === 1'b1, "R2 strobe", longint'(vld), 1);
    check({hit, port} === e, rq, longint'({hit, port}), longint'(e));
    @(negedge clk);
    check({vld, hit, port} === 10'd0, "R2 idle", longint'({vld, hit, port}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({vld, hit, port} === 10'd0, "R1 outputs", longint'({vld, hit, port}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({vld, hit, port} === 10'd0, "R1 after release", longint'({vld, hit, port}), 0);
    look(52'h12345, "R1 uncommitted at reset");

    // sweep: commit x ways x granularity x 16 strides
    for (int cm = 0; cm < 2; cm++) begin
      for (int iw = 0; iw < 6; iw++) begin
        for (int ig = 0; ig < 7; ig++) begin
          logic [31:0] lo, hi;
          for (int b = 0; b < 4; b++) begin
            lo[b*8 +: 8] = 8'(b * 29 + iw * 7 + ig * 3 + 1);
            hi[b*8 +: 8] = 8'((b + 4) * 29 + iw * 7 + ig * 3 + 1);
          end
          wr(4'h4, lo);
          wr(4'h8, hi);
          wr(4'h0, 32'(cm) | (32'(ig) << 4) | (32'(iw) << 8));
          for (int s = 0; s < 16; s++) begin
            longint unsigned g;
            logic [51:0] a;
            g = 64'd256 << ig;
            a = 52'((64'(s) * g) + ((64'(s) * 37 + 5) % g) + (64'(s + 1) << 40));
            if (cm == 0)     look(a, "R3 uncommitted");
            else if (iw > 3) look(a, "R4 bad ways");
            else             look(a, "R5 R6 decode");
          end
        end
      end
    end

    // R9 low bits ignored: same stride, different offsets
    wr(4'h4, 32'h44332211);
    wr(4'h8, 32'h88776655);
    wr(4'h0, 32'h0000_0321); // commit, G=2, W=3
    for (int s = 0; s < 8; s++) begin
      look(52'(s * 1024), "R9 base of stride");
      look(52'(s * 1024 + 1023), "R9 top of stride");
    end

    // R7 unmapped offsets change nothing
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h1, 32'h0000_0000);
    wr(4'h6, 32'hDEAD_BEEF);
    for (int s = 0; s < 8; s++) look(52'(s * 1024), "R7 unmapped write ignored");

    // R8 write in same cycle as request: old contents used
    @(negedge clk);
    we = 1'b1; waddr = 4'h4; wdata = 32'hA5A5_A5A5;
    req = 1'b1; addr = 52'h0;
    @(negedge clk);
    we = 1'b0; req = 1'b0;
    check({hit, port} === 9'h111, "R8 old value used", longint'({hit, port}), 'h111);
    m_lo = 32'hA5A5_A5A5;
    look(52'h0, "R8 new value next lookup");
    @(negedge clk);
    we = 1'b1; waddr = 4'h0; wdata = 32'h0;
    req = 1'b1; addr = 52'h400;
    @(negedge clk);
    we = 1'b0; req = 1'b0;
    check({hit, port} === 9'h1A5, "R8 commit clear lands late", longint'({hit, port}), 'h1A5);
    m_ctrl = 32'h0;
    look(52'h400, "R8 R3 cleared commit");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule